// File: doc/BRIEF.md
# Memory Scan-Test Bypass Wrapper

This wrapper sits between the surrounding logic and an embedded memory array, so that scan-based test can treat the array as if it had been cut out of the netlist. Address, write data and the read/write strobes going to the array are sampled into observe-only registers. The wrapper can therefore see the logic that drives the memory even though the array itself takes no part in scan test.

A 2-bit test-mode input selects what the memory read-data path carries. With the mode at zero, the real array output passes through unchanged. The three scan modes are different. One drives a fixed constant onto the output. One routes the write-data bus straight to the read-data output through a multiplexer. The last keeps a single register that stands in for one memory word. That register loads on a write strobe and returns its contents one cycle after a read strobe, as a synchronous memory would. In this last mode the emulating register already observes the write data, so the observe-only data register keeps its value.

Top module: `mem_bypass_wrap`

## Requirements
- R1: With test_mode = 2'b00 (functional), dout_o equals mem_rdata_i in the same cycle, whatever the other inputs are.
- R2: With test_mode = 2'b01 (blocked), dout_o equals the constant BLOCK_VAL (0xAAAA at default width) in the same cycle, regardless of mem_rdata_i and wdata_i.
- R3: With test_mode = 2'b10 (pass-through), dout_o equals wdata_i in the same cycle.
- R4: With test_mode = 2'b11 (fake word), a clock edge with wr_i = 1 loads wdata_i into the word register. A clock edge with rd_i = 1 puts the stored word on dout_o, visible after that edge, and dout_o keeps this value until the next read edge.
- R5: The word register is unchanged by any edge without wr_i = 1 in fake-word mode. This includes writes made while another mode is selected.
- R6: When wr_i and rd_i are both 1 at one edge in fake-word mode, the read returns the word held before that edge. The next read returns the newly written data.
- R7: In any scan mode (test_mode ≠ 2'b00), every edge copies addr_i into obs_addr_o and {rd_i, wr_i} into obs_ctrl_o, with bit 1 = read and bit 0 = write. In functional mode both registers hold their values.
- R8: In blocked and pass-through modes, every edge copies wdata_i into obs_wdata_o. In functional and fake-word modes, obs_wdata_o holds its value.
- R9: During reset the observe registers, the word register and the fake read output all clear to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| test_mode | input | 2 | 00 functional, 01 blocked, 10 pass-through, 11 fake word |
| addr_i | input | ADDR_W | Address going to the array |
| wdata_i | input | DATA_W | Write data going to the array |
| wr_i | input | 1 | Write strobe going to the array |
| rd_i | input | 1 | Read strobe going to the array |
| mem_rdata_i | input | DATA_W | Read data coming back from the real array |
| dout_o | output | DATA_W | Read data presented to the surrounding logic |
| obs_addr_o | output | ADDR_W | Observe register for the address |
| obs_wdata_o | output | DATA_W | Observe register for the write data |
| obs_ctrl_o | output | 2 | Observe register for the strobes: bit 1 read, bit 0 write |

## Verification
The functional, blocked and pass-through outputs are combinational. The bench drives inputs at the falling edge and checks dout_o two nanoseconds later, before any rising edge. The observe registers and the fake-word output each sit one register from their inputs, so they are checked two nanoseconds after the rising edge that captures the stimulus. The fake-word checks also look once before that edge, to show that a read is not visible early. Hold behaviour is checked one edge after a stimulus that must leave the register untouched, with different input values applied during that edge.

// File: rtl/bypass_pkg.sv
package bypass_pkg;

    typedef enum logic [1:0] {
        MODE_FUNC  = 2'b00,
        MODE_BLOCK = 2'b01,
        MODE_PASS  = 2'b10,
        MODE_FAKE  = 2'b11
    } tmode_e;

    typedef enum logic [1:0] {
        OSEL_MEM   = 2'b00,
        OSEL_CONST = 2'b01,
        OSEL_DIN   = 2'b10,
        OSEL_WORD  = 2'b11
    } osel_e;

    typedef struct packed {
        logic  scan_act;   // capture address and strobes
        logic  cap_din;    // capture write data
        logic  fake_en;    // word register active
        osel_e osel;       // output source
    } dec_t;

endpackage

// File: rtl/bypass_mode_dec.sv
module bypass_mode_dec
    import bypass_pkg::*;
(
    input  logic [1:0] mode_i,
    output dec_t       dec_o
);

    always_comb begin
        dec_o = '0;
        case (tmode_e'(mode_i))
            MODE_FUNC: begin
                dec_o.osel = OSEL_MEM;
            end
            MODE_BLOCK: begin
                dec_o.scan_act = 1'b1;
                dec_o.cap_din  = 1'b1;
                dec_o.osel     = OSEL_CONST;
            end
            MODE_PASS: begin
                dec_o.scan_act = 1'b1;
                dec_o.cap_din  = 1'b1;
                dec_o.osel     = OSEL_DIN;
            end
            default: begin
                dec_o.scan_act = 1'b1;
                dec_o.fake_en  = 1'b1;
                dec_o.osel     = OSEL_WORD;
            end
        endcase
    end

endmodule

// File: rtl/bypass_obs_regs.sv
module bypass_obs_regs #(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scan_act_i,
    input  logic              cap_din_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [DATA_W-1:0] wdata_i,
    input  logic              wr_i,
    input  logic              rd_i,
    output logic [ADDR_W-1:0] obs_addr_o,
    output logic [DATA_W-1:0] obs_wdata_o,
    output logic [1:0]        obs_ctrl_o
);

    typedef struct packed {
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] wdata;
        logic [1:0]        ctrl;
    } obs_t;

    obs_t st_d, st_q;
    logic past_ok_q;

    always_comb begin
        st_d = st_q;
        if (scan_act_i) begin
            st_d.addr = addr_i;
            st_d.ctrl = {rd_i, wr_i};
        end
        if (cap_din_i) begin
            st_d.wdata = wdata_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q      <= '0;
            past_ok_q <= 1'b0;
        end else begin
            st_q      <= st_d;
            past_ok_q <= 1'b1;
        end
    end

    assign obs_addr_o  = st_q.addr;
    assign obs_wdata_o = st_q.wdata;
    assign obs_ctrl_o  = st_q.ctrl;

    p_obs_cap_r7: assert property (@(posedge clk) disable iff (!rst_n)
        past_ok_q && $past(scan_act_i) |-> obs_addr_o == $past(addr_i)
                                        && obs_ctrl_o == $past({rd_i, wr_i}));

    p_obs_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        past_ok_q && $past(!scan_act_i) |-> $stable(obs_addr_o) && $stable(obs_ctrl_o));

    p_obs_din_r8: assert property (@(posedge clk) disable iff (!rst_n)
        past_ok_q && $past(!cap_din_i) |-> $stable(obs_wdata_o));

endmodule

// File: rtl/bypass_fake_word.sv
module bypass_fake_word #(
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en_i,
    input  logic              wr_i,
    input  logic              rd_i,
    input  logic [DATA_W-1:0] wdata_i,
    output logic [DATA_W-1:0] rdata_o
);

    typedef struct packed {
        logic [DATA_W-1:0] word;
        logic [DATA_W-1:0] rd;
    } fw_t;

    fw_t  st_d, st_q;
    logic past_ok_q;

    always_comb begin
        st_d = st_q;
        if (en_i) begin
            if (rd_i) st_d.rd   = st_q.word;
            if (wr_i) st_d.word = wdata_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q      <= '0;
            past_ok_q <= 1'b0;
        end else begin
            st_q      <= st_d;
            past_ok_q <= 1'b1;
        end
    end

    assign rdata_o = st_q.rd;

    p_wr_load_r4: assert property (@(posedge clk) disable iff (!rst_n)
        past_ok_q && $past(en_i && wr_i) |-> st_q.word == $past(wdata_i));

    p_rd_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        past_ok_q && $past(!(en_i && rd_i)) |-> $stable(rdata_o));

    p_word_keep_r5: assert property (@(posedge clk) disable iff (!rst_n)
        past_ok_q && $past(!(en_i && wr_i)) |-> $stable(st_q.word));

    p_rd_old_r6: assert property (@(posedge clk) disable iff (!rst_n)
        past_ok_q && $past(en_i && rd_i) |-> rdata_o == $past(st_q.word));

endmodule

// File: rtl/bypass_out_mux.sv
module bypass_out_mux
    import bypass_pkg::*;
#(
    parameter int                DATA_W    = 16,
    parameter logic [DATA_W-1:0] CONST_VAL = '0
) (
    input  osel_e             osel_i,
    input  logic [DATA_W-1:0] mem_i,
    input  logic [DATA_W-1:0] din_i,
    input  logic [DATA_W-1:0] word_i,
    output logic [DATA_W-1:0] dout_o
);

    always_comb begin
        case (osel_i)
            OSEL_MEM:   dout_o = mem_i;
            OSEL_CONST: dout_o = CONST_VAL;
            OSEL_DIN:   dout_o = din_i;
            default:    dout_o = word_i;
        endcase
    end

endmodule

// File: rtl/mem_bypass_wrap.sv
module mem_bypass_wrap
    import bypass_pkg::*;
#(
    parameter int                ADDR_W    = 8,
    parameter int                DATA_W    = 16,
    parameter logic [DATA_W-1:0] BLOCK_VAL = {(DATA_W/2){2'b10}}
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        test_mode,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [DATA_W-1:0] wdata_i,
    input  logic              wr_i,
    input  logic              rd_i,
    input  logic [DATA_W-1:0] mem_rdata_i,
    output logic [DATA_W-1:0] dout_o,
    output logic [ADDR_W-1:0] obs_addr_o,
    output logic [DATA_W-1:0] obs_wdata_o,
    output logic [1:0]        obs_ctrl_o
);

    dec_t              dec;
    logic [DATA_W-1:0] fake_rdata;

    bypass_mode_dec u_dec (
        .mode_i (test_mode),
        .dec_o  (dec)
    );

    bypass_obs_regs #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W)
    ) u_obs (
        .clk         (clk),
        .rst_n       (rst_n),
        .scan_act_i  (dec.scan_act),
        .cap_din_i   (dec.cap_din),
        .addr_i      (addr_i),
        .wdata_i     (wdata_i),
        .wr_i        (wr_i),
        .rd_i        (rd_i),
        .obs_addr_o  (obs_addr_o),
        .obs_wdata_o (obs_wdata_o),
        .obs_ctrl_o  (obs_ctrl_o)
    );

    bypass_fake_word #(
        .DATA_W (DATA_W)
    ) u_fake (
        .clk     (clk),
        .rst_n   (rst_n),
        .en_i    (dec.fake_en),
        .wr_i    (wr_i),
        .rd_i    (rd_i),
        .wdata_i (wdata_i),
        .rdata_o (fake_rdata)
    );

    bypass_out_mux #(
        .DATA_W    (DATA_W),
        .CONST_VAL (BLOCK_VAL)
    ) u_mux (
        .osel_i (dec.osel),
        .mem_i  (mem_rdata_i),
        .din_i  (wdata_i),
        .word_i (fake_rdata),
        .dout_o (dout_o)
    );

    p_func_r1: assert property (@(posedge clk) disable iff (!rst_n)
        test_mode == 2'b00 |-> dout_o == mem_rdata_i);

    p_block_r2: assert property (@(posedge clk) disable iff (!rst_n)
        test_mode == 2'b01 |-> dout_o == BLOCK_VAL);

    p_pass_r3: assert property (@(posedge clk) disable iff (!rst_n)
        test_mode == 2'b10 |-> dout_o == wdata_i);

endmodule

// File: tb/tb_mem_bypass_wrap.sv
module tb_mem_bypass_wrap;

    localparam int ADDR_W = 8;
    localparam int DATA_W = 16;
    localparam logic [DATA_W-1:0] BLK = 16'hAAAA;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [1:0]        test_mode = 2'b00;
    logic [ADDR_W-1:0] addr_i = '0;
    logic [DATA_W-1:0] wdata_i = '0;
    logic              wr_i = 1'b0;
    logic              rd_i = 1'b0;
    logic [DATA_W-1:0] mem_rdata_i = '0;
    logic [DATA_W-1:0] dout_o;
    logic [ADDR_W-1:0] obs_addr_o;
    logic [DATA_W-1:0] obs_wdata_o;
    logic [1:0]        obs_ctrl_o;

    int checks = 0;
    int fails  = 0;

    always #10 clk = ~clk;

    mem_bypass_wrap #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) dut (
        .clk (clk), .rst_n (rst_n), .test_mode (test_mode),
        .addr_i (addr_i), .wdata_i (wdata_i), .wr_i (wr_i), .rd_i (rd_i),
        .mem_rdata_i (mem_rdata_i), .dout_o (dout_o),
        .obs_addr_o (obs_addr_o), .obs_wdata_o (obs_wdata_o), .obs_ctrl_o (obs_ctrl_o)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic drive(input logic [1:0] m, input logic [ADDR_W-1:0] a,
                         input logic [DATA_W-1:0] d, input logic w, input logic r,
                         input logic [DATA_W-1:0] mem);
        @(negedge clk);
        test_mode = m; addr_i = a; wdata_i = d; wr_i = w; rd_i = r; mem_rdata_i = mem;
        #2;
    endtask

    task automatic after_edge();
        @(posedge clk);
        #2;
    endtask

    task automatic t_reset();
        chk("R9 obs_addr", 32'(obs_addr_o), 0);
        chk("R9 obs_wdata", 32'(obs_wdata_o), 0);
        chk("R9 obs_ctrl", 32'(obs_ctrl_o), 0);
        drive(2'b11, 8'h00, 16'h0000, 1'b0, 1'b0, 16'h1111);
        chk("R9 fake output", 32'(dout_o), 0);
    endtask

    task automatic t_functional();
        drive(2'b00, 8'h01, 16'h9999, 1'b1, 1'b0, 16'h1234);
        chk("R1 mem 1234", 32'(dout_o), 32'h1234);
        drive(2'b00, 8'h02, 16'h0000, 1'b0, 1'b1, 16'hFFFF);
        chk("R1 mem FFFF", 32'(dout_o), 32'hFFFF);
    endtask

    task automatic t_block();
        drive(2'b01, 8'h03, 16'h1111, 1'b0, 1'b0, 16'h5555);
        chk("R2 const a", 32'(dout_o), 32'(BLK));
        drive(2'b01, 8'h04, 16'hFFFF, 1'b1, 1'b1, 16'h0000);
        chk("R2 const b", 32'(dout_o), 32'(BLK));
    endtask

    task automatic t_pass();
        drive(2'b10, 8'h05, 16'h0F0F, 1'b0, 1'b0, 16'h7777);
        chk("R3 pass 0F0F", 32'(dout_o), 32'h0F0F);
        drive(2'b10, 8'h06, 16'hC3C3, 1'b0, 1'b0, 16'h7777);
        chk("R3 pass C3C3", 32'(dout_o), 32'hC3C3);
    endtask

    task automatic t_observe();
        drive(2'b10, 8'h5A, 16'h7E7E, 1'b1, 1'b0, 16'h0000);
        after_edge();
        chk("R7 capture addr", 32'(obs_addr_o), 32'h5A);
        chk("R7 capture ctrl", 32'(obs_ctrl_o), 32'h1);
        chk("R8 capture wdata", 32'(obs_wdata_o), 32'h7E7E);
        drive(2'b00, 8'h11, 16'h2222, 1'b0, 1'b1, 16'h0000);
        after_edge();
        chk("R7 hold addr in functional", 32'(obs_addr_o), 32'h5A);
        chk("R7 hold ctrl in functional", 32'(obs_ctrl_o), 32'h1);
        chk("R8 hold wdata in functional", 32'(obs_wdata_o), 32'h7E7E);
        drive(2'b11, 8'h33, 16'h4444, 1'b0, 1'b0, 16'h0000);
        after_edge();
        chk("R7 capture addr in fake", 32'(obs_addr_o), 32'h33);
        chk("R7 capture ctrl in fake", 32'(obs_ctrl_o), 32'h0);
        chk("R8 hold wdata in fake", 32'(obs_wdata_o), 32'h7E7E);
        drive(2'b01, 8'h44, 16'h9999, 1'b0, 1'b1, 16'h0000);
        after_edge();
        chk("R8 capture wdata in blocked", 32'(obs_wdata_o), 32'h9999);
        chk("R7 capture ctrl read", 32'(obs_ctrl_o), 32'h2);
    endtask

    task automatic t_fake();
        drive(2'b11, 8'h00, 16'hBEEF, 1'b1, 1'b0, 16'h0000);
        after_edge();
        chk("R4 write not shown", 32'(dout_o), 0);
        drive(2'b11, 8'h00, 16'h0000, 1'b0, 1'b1, 16'h0000);
        chk("R4 read not early", 32'(dout_o), 0);
        after_edge();
        chk("R4 read latency", 32'(dout_o), 32'hBEEF);
        drive(2'b11, 8'h00, 16'h1357, 1'b0, 1'b0, 16'h0000);
        after_edge();
        chk("R4 output holds", 32'(dout_o), 32'hBEEF);
        drive(2'b11, 8'h00, 16'h2468, 1'b0, 1'b1, 16'h0000);
        after_edge();
        chk("R5 no write keeps word", 32'(dout_o), 32'hBEEF);
        drive(2'b11, 8'h00, 16'hCAFE, 1'b1, 1'b1, 16'h0000);
        after_edge();
        chk("R6 same-edge read old", 32'(dout_o), 32'hBEEF);
        drive(2'b11, 8'h00, 16'h0000, 1'b0, 1'b1, 16'h0000);
        after_edge();
        chk("R6 next read new", 32'(dout_o), 32'hCAFE);
        drive(2'b10, 8'h00, 16'h0001, 1'b1, 1'b0, 16'h0000);
        after_edge();
        drive(2'b11, 8'h00, 16'h0000, 1'b0, 1'b1, 16'h0000);
        after_edge();
        chk("R5 write in other mode ignored", 32'(dout_o), 32'hCAFE);
    endtask

    initial begin
        #(20 * 5000);
        fails++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        #2;
        t_reset();
        t_functional();
        t_block();
        t_pass();
        t_observe();
        t_fake();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule